// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one processor core and gives it atomic read-modify-write through a load-linked / store-conditional pair. Each hardware thread of the core owns one reservation slot. A load-linked fills that slot with the 16-byte cache line of its address and returns the memory word supplied by the cache. A store-conditional is allowed to reach the shared bus only if that reservation is still intact.

The monitor also watches the shared bus. A write or an invalidate that targets a reserved line marks the reservation as broken. A store-conditional on a broken or missing reservation returns the failure code 0 and causes no bus transaction. A store-conditional on an intact reservation returns 1 and raises a single bus write request carrying its address and data. Either way the store-conditional uses up the reservation.

All results leave the block one clock after the request. Between a load-linked and its store-conditional, any number of idle cycles or other traffic that does not touch the line leaves the reservation alone.

Top module: `llsc_monitor`

## Requirements
- R1: In reset and in the first cycle after it, `rsp_valid` and `bus_wr_valid` are 0, and every reservation is empty, so a store-conditional issued straight after reset fails.
- R2: A load-linked (`req_op`=0) gives `rsp_valid`=1 one cycle later, with `rsp_data` equal to the `mem_rdata` sampled with the request and `bus_wr_valid`=0. It also records the line `req_addr[31:4]` for thread `req_tid`.
- R3: A store-conditional (`req_op`=1) whose thread holds an intact reservation on the same line returns `rsp_data`=1 one cycle later. In that same cycle it raises `bus_wr_valid`=1, with `bus_wr_addr`/`bus_wr_data` equal to the request's address and data.
- R4: A failing store-conditional returns `rsp_valid`=1 with `rsp_data`=0, and `bus_wr_valid` stays 0.
- R5: A snooped write (`snoop_kind`=01), invalidate (10) or read-exclusive (11) whose `snoop_line` equals a reserved line breaks that reservation, and a later store-conditional to it fails.
- R6: A snooped read (`snoop_kind`=00), or a snoop of any kind to a different line, leaves reservations intact.
- R7: A store-conditional consumes its thread's reservation whether it succeeds or fails, so a second store-conditional fails.
- R8: A new load-linked replaces the thread's older reservation. A store-conditional to the old line then fails, and one to the new line succeeds.
- R9: When a breaking snoop and a store-conditional to the same line arrive in the same cycle, the snoop wins and the store-conditional fails.
- R10: When a breaking snoop and a load-linked to the same line arrive in the same cycle, the load-linked still returns its data, but its reservation starts out broken.
- R11: A store-conditional to a line other than the one its thread reserved fails. Addresses are compared at line granularity, so a different word in the same line matches.
- R12: A successful store-conditional breaks other threads' reservations on the same line and keeps their reservations on other lines.
- R13: Reservations of different threads are independent, and idle cycles between a load-linked and its store-conditional do not affect the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Local request present this cycle |
| req_op | input | 1 | 0 = load-linked, 1 = store-conditional |
| req_tid | input | 2 | Issuing hardware thread |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Store-conditional data |
| mem_rdata | input | 32 | Memory word for a load-linked, valid with the request |
| snoop_valid | input | 1 | Snooped bus transaction present |
| snoop_kind | input | 2 | 00 read, 01 write, 10 invalidate, 11 read-exclusive |
| snoop_line | input | 28 | Line address of the snooped transaction |
| rsp_valid | output | 1 | Result present |
| rsp_tid | output | 2 | Thread of the result |
| rsp_is_sc | output | 1 | Result belongs to a store-conditional |
| rsp_data | output | 32 | Load data, or 1/0 for store-conditional success/failure |
| bus_wr_valid | output | 1 | Request to issue a bus write |
| bus_wr_addr | output | 32 | Address of the bus write |
| bus_wr_data | output | 32 | Data of the bus write |

## Verification
The bench targets cycles where two events meet. A snoop and a store-conditional to the same line in one cycle must fail, and a design that let the local request win would issue a write after losing the line. A snoop that coincides with a load-linked must leave a broken reservation, and getting this wrong gives a silent success on stale data. The bench also covers a second store-conditional after the first, a load-linked that replaces an older one, a store-conditional to a different word of the reserved line, and a peer thread's success on a shared line. A monitor that failed to consume, replace or cross-invalidate would let two threads both "win" the same lock.

// File: rtl/llsc_pkg.sv
// Package: shared encodings for the reservation monitor.
// Assumes snoop kinds arrive already decoded from the bus protocol.
package llsc_pkg;

    typedef enum logic {
        OP_LOAD_LINK  = 1'b0,
        OP_STORE_COND = 1'b1
    } llsc_op_e;

    typedef enum logic [1:0] {
        SNP_READ  = 2'b00,
        SNP_WRITE = 2'b01,
        SNP_INVAL = 2'b10,
        SNP_RDX   = 2'b11
    } snoop_kind_e;

    // True for snoop kinds that take ownership of a line away from this core.
    function automatic logic kind_breaks_link(input logic [1:0] kind);
        return kind != SNP_READ;
    endfunction

endpackage

// File: rtl/llsc_snoop_qual.sv
// Module: qualifies the snooped bus stream into a single "line lost" event.
// Assumes one snoop per cycle at line granularity; reads never break links.
module llsc_snoop_qual #(
    parameter int TAG_W = 28
) (
    input  logic             snoop_valid,
    input  logic [1:0]       snoop_kind,
    input  logic [TAG_W-1:0] snoop_line,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             brk_valid,
    output logic [TAG_W-1:0] brk_tag,
    output logic             brk_hits_probe
);
    import llsc_pkg::*;

    // Decide whether this snoop removes the line from this core.
    always_comb begin
        brk_valid      = snoop_valid && kind_breaks_link(snoop_kind);
        brk_tag        = snoop_line;
        brk_hits_probe = brk_valid && (snoop_line == probe_tag);
    end

    // R6: a snooped read never produces a break event.
    always_comb begin
        if (snoop_valid && snoop_kind == 2'b00)
            assert_read_harmless_R6: assert (!brk_valid);
    end

endmodule

// File: rtl/llsc_resv_entry.sv
// Module: one reservation slot (valid, line tag, broken flag) for one thread.
// Assumes the owner's load-linked and store-conditional are mutually exclusive
// in a cycle. A break from a snoop or a peer's successful store only marks the flag.
module llsc_resv_entry #(
    parameter int TAG_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ll_set,
    input  logic             sc_take,
    input  logic [TAG_W-1:0] new_tag,
    input  logic             new_broken,
    input  logic             brk_valid,
    input  logic [TAG_W-1:0] brk_tag,
    input  logic             peer_valid,
    input  logic [TAG_W-1:0] peer_tag,
    output logic             ent_valid,
    output logic [TAG_W-1:0] ent_tag,
    output logic             ent_broken
);
    logic hit_break;

    // Any foreign claim on the line this slot holds.
    always_comb begin
        hit_break = ent_valid &&
                    ((brk_valid && brk_tag == ent_tag) ||
                     (peer_valid && peer_tag == ent_tag));
    end

    // Slot state: the owner's requests take priority over break marking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid  <= 1'b0;
            ent_tag    <= '0;
            ent_broken <= 1'b0;
        end else if (ll_set) begin
            ent_valid  <= 1'b1;
            ent_tag    <= new_tag;
            ent_broken <= new_broken;
        end else if (sc_take) begin
            ent_valid  <= 1'b0;
            ent_broken <= 1'b0;
        end else if (hit_break) begin
            ent_broken <= 1'b1;
        end
    end

    assert_ll_records_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ll_set |=> (ent_valid && ent_tag == $past(new_tag)));

    assert_sc_consumes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_take && !ll_set) |=> !ent_valid);

    assert_break_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_break && !ll_set && !sc_take) |=> ent_broken);

    assert_broken_sticks_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_broken && !ll_set && !sc_take) |=> ent_broken);

endmodule

// File: rtl/llsc_resp_stage.sv
// Module: output register stage for processor results and the bus write request.
// Assumes at most one request per cycle; all outputs change one clock after it.
module llsc_resp_stage #(
    parameter int TID_W  = 2,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [TID_W-1:0]  in_tid,
    input  logic              in_is_sc,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_wr,
    input  logic [ADDR_W-1:0] in_wr_addr,
    input  logic [DATA_W-1:0] in_wr_data,
    output logic              rsp_valid,
    output logic [TID_W-1:0]  rsp_tid,
    output logic              rsp_is_sc,
    output logic [DATA_W-1:0] rsp_data,
    output logic              bus_wr_valid,
    output logic [ADDR_W-1:0] bus_wr_addr,
    output logic [DATA_W-1:0] bus_wr_data
);

    // Register the processor-facing result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_tid   <= '0;
            rsp_is_sc <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= in_valid;
            rsp_tid   <= in_tid;
            rsp_is_sc <= in_is_sc;
            rsp_data  <= in_data;
        end
    end

    // Register the bus write request; only an approved store reaches here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_wr_valid <= 1'b0;
            bus_wr_addr  <= '0;
            bus_wr_data  <= '0;
        end else begin
            bus_wr_valid <= in_wr;
            bus_wr_addr  <= in_wr_addr;
            bus_wr_data  <= in_wr_data;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !bus_wr_valid));

endmodule

// File: rtl/llsc_monitor.sv
// Module: per-core load-linked / store-conditional reservation monitor.
// One slot per hardware thread, line-granular compare, snoop beats local SC,
// result and bus write one cycle after the request.
// Assumes NUM_THREADS is a power of two and the cache supplies mem_rdata with the load-linked.
module llsc_monitor #(
    parameter int NUM_THREADS = 4,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int LINE_BYTES  = 16,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int TAG_W      = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              snoop_valid,
    input  logic [1:0]        snoop_kind,
    input  logic [TAG_W-1:0]  snoop_line,
    output logic              rsp_valid,
    output logic [TID_W-1:0]  rsp_tid,
    output logic              rsp_is_sc,
    output logic [DATA_W-1:0] rsp_data,
    output logic              bus_wr_valid,
    output logic [ADDR_W-1:0] bus_wr_addr,
    output logic [DATA_W-1:0] bus_wr_data
);
    import llsc_pkg::*;

    logic [TAG_W-1:0] req_tag;
    logic             is_ll, is_sc;
    logic             brk_valid, brk_hits_req;
    logic [TAG_W-1:0] brk_tag;
    logic             sc_ok;
    logic [DATA_W-1:0] result_data;

    logic             ent_valid  [NUM_THREADS];
    logic             ent_broken [NUM_THREADS];
    logic [TAG_W-1:0] ent_tag    [NUM_THREADS];

    // Split the request into its line tag and decode the operation.
    always_comb begin
        req_tag = req_addr[ADDR_W-1:OFF_W];
        is_ll   = req_valid && (req_op == OP_LOAD_LINK);
        is_sc   = req_valid && (req_op == OP_STORE_COND);
    end

    llsc_snoop_qual #(.TAG_W(TAG_W)) u_snoop (
        .snoop_valid    (snoop_valid),
        .snoop_kind     (snoop_kind),
        .snoop_line     (snoop_line),
        .probe_tag      (req_tag),
        .brk_valid      (brk_valid),
        .brk_tag        (brk_tag),
        .brk_hits_probe (brk_hits_req)
    );

    // Store-conditional verdict: intact slot, same line, no coincident snoop.
    always_comb begin
        sc_ok = is_sc &&
                ent_valid[req_tid] &&
                !ent_broken[req_tid] &&
                (ent_tag[req_tid] == req_tag) &&
                !brk_hits_req;
    end

    // Result word: load data for a load-linked, 1/0 for a store-conditional.
    always_comb begin
        if (is_sc) result_data = {{(DATA_W-1){1'b0}}, sc_ok};
        else       result_data = mem_rdata;
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
        llsc_resv_entry #(.TAG_W(TAG_W)) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .ll_set     (is_ll && (req_tid == TID_W'(t))),
            .sc_take    (is_sc && (req_tid == TID_W'(t))),
            .new_tag    (req_tag),
            .new_broken (brk_hits_req),
            .brk_valid  (brk_valid),
            .brk_tag    (brk_tag),
            .peer_valid (sc_ok),
            .peer_tag   (req_tag),
            .ent_valid  (ent_valid[t]),
            .ent_tag    (ent_tag[t]),
            .ent_broken (ent_broken[t])
        );
    end

    llsc_resp_stage #(
        .TID_W  (TID_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_resp (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (req_valid),
        .in_tid       (req_tid),
        .in_is_sc     (is_sc),
        .in_data      (result_data),
        .in_wr        (sc_ok),
        .in_wr_addr   (req_addr),
        .in_wr_data   (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_tid      (rsp_tid),
        .rsp_is_sc    (rsp_is_sc),
        .rsp_data     (rsp_data),
        .bus_wr_valid (bus_wr_valid),
        .bus_wr_addr  (bus_wr_addr),
        .bus_wr_data  (bus_wr_data)
    );

    assert_ll_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_ll |=> (rsp_valid && !rsp_is_sc && !bus_wr_valid));

    assert_fail_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sc && !sc_ok) |=> (rsp_valid && rsp_data == '0 && !bus_wr_valid));

    assert_snoop_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sc && brk_hits_req) |=> (!bus_wr_valid && rsp_data == '0));

    assert_write_only_on_sc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_valid |-> (rsp_valid && rsp_is_sc && rsp_data == DATA_W'(1)));

    assert_other_line_fails_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sc && ent_tag[req_tid] != req_tag) |=> !bus_wr_valid);

endmodule

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_op = 1'b0;
    logic [1:0]  req_tid = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] mem_rdata = '0;
    logic        snoop_valid = 1'b0;
    logic [1:0]  snoop_kind = '0;
    logic [27:0] snoop_line = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_tid;
    logic        rsp_is_sc;
    logic [31:0] rsp_data;
    logic        bus_wr_valid;
    logic [31:0] bus_wr_addr;
    logic [31:0] bus_wr_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    llsc_monitor dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_tid(req_tid),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_rdata(mem_rdata),
        .snoop_valid(snoop_valid), .snoop_kind(snoop_kind), .snoop_line(snoop_line),
        .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_is_sc(rsp_is_sc),
        .rsp_data(rsp_data), .bus_wr_valid(bus_wr_valid),
        .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data)
    );

    // rv, sc, tid, addr, wdata, rdata, snoop valid/kind/addr, expected rsp valid/data/bus write, requirement number
    typedef struct packed {
        logic        rv;
        logic        sc;
        logic [1:0]  tid;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [31:0] rd;
        logic        sv;
        logic [1:0]  sk;
        logic [31:0] sa;
        logic        erv;
        logic [31:0] ed;
        logic        ebw;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1,0,0,32'h100,0,32'hAAAA,0,0,0,        1,32'hAAAA,0,2},  // R2 LL t0
        '{0,0,0,0,0,0,0,0,0,                      0,0,0,13},        // R13 idle gap
        '{1,1,0,32'h100,32'h1,0,0,0,0,            1,1,1,3},         // R3 SC ok
        '{1,1,0,32'h100,32'h2,0,0,0,0,            1,0,0,7},         // R7 consumed
        '{1,0,1,32'h200,0,32'h5,0,0,0,            1,5,0,2},         // R2 LL t1
        '{0,0,0,0,0,0,1,1,32'h20C,                0,0,0,5},         // R5 snoop write
        '{1,1,1,32'h200,32'h3,0,0,0,0,            1,0,0,5},         // R5 SC fails
        '{1,0,1,32'h200,0,32'h0,0,0,0,            1,0,0,2},         // R2 LL again
        '{0,0,0,0,0,0,1,0,32'h200,                0,0,0,6},         // R6 snoop read
        '{0,0,0,0,0,0,1,2,32'h210,                0,0,0,6},         // R6 other line
        '{1,1,1,32'h200,32'h4,0,0,0,0,            1,1,1,6},         // R6 SC ok
        '{1,0,2,32'h300,0,32'h7,0,0,0,            1,7,0,2},         // R2 LL t2
        '{1,1,2,32'h300,32'h5,0,1,2,32'h304,      1,0,0,9},         // R9 same-cycle snoop
        '{1,0,3,32'h400,0,32'h9,1,1,32'h408,      1,9,0,10},        // R10 LL + snoop
        '{1,1,3,32'h400,32'h6,0,0,0,0,            1,0,0,10},        // R10 SC fails
        '{1,0,0,32'h500,0,32'h11,0,0,0,           1,32'h11,0,8},    // R8 old LL
        '{1,0,0,32'h600,0,32'h22,0,0,0,           1,32'h22,0,8},    // R8 new LL
        '{1,1,0,32'h500,32'h7,0,0,0,0,            1,0,0,8},         // R8 old line fails
        '{1,0,0,32'h600,0,32'h22,0,0,0,           1,32'h22,0,8},    // R8 LL new
        '{1,1,0,32'h600,32'h8,0,0,0,0,            1,1,1,8},         // R8 new line ok
        '{1,0,1,32'h700,0,32'h33,0,0,0,           1,32'h33,0,11},   // R11 LL
        '{1,1,1,32'h780,32'h9,0,0,0,0,            1,0,0,11},        // R11 other line
        '{1,0,2,32'h800,0,32'h44,0,0,0,           1,32'h44,0,12},   // R12 LL t2
        '{1,0,3,32'h804,0,32'h55,1,3,32'hC00,     1,32'h55,0,12},   // R12 LL t3, snoop rdx elsewhere
        '{1,1,2,32'h808,32'hA,0,0,0,0,            1,1,1,11},        // R11 same line other word
        '{1,1,3,32'h804,32'hB,0,0,0,0,            1,0,0,12}         // R12 peer broke t3
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_valid   = v.rv;
        req_op      = v.sc;
        req_tid     = v.tid;
        req_addr    = v.addr;
        req_wdata   = v.wd;
        mem_rdata   = v.rd;
        snoop_valid = v.sv;
        snoop_kind  = v.sk;
        snoop_line  = v.sa[31:4];
    endtask

    task automatic check_vec(input vec_t v);
        string t;
        t = $sformatf("R%0d", v.req);
        chk({t, " rsp_valid"}, {31'b0, rsp_valid}, {31'b0, v.erv});
        if (v.erv) chk({t, " rsp_data"}, rsp_data, v.ed);
        chk({t, " bus_wr_valid"}, {31'b0, bus_wr_valid}, {31'b0, v.ebw});
        if (v.ebw) begin
            chk({t, " bus_wr_addr"}, bus_wr_addr, v.addr);
            chk({t, " bus_wr_data"}, bus_wr_data, v.wd);
        end
    endtask

    function automatic vec_t mk(input logic rv, input logic sc, input logic [1:0] tid,
                                input logic [31:0] addr, input logic [31:0] wd);
        vec_t v;
        v = '0;
        v.rv = rv; v.sc = sc; v.tid = tid; v.addr = addr; v.wd = wd;
        return v;
    endfunction

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 rsp_valid in reset", {31'b0, rsp_valid}, 0);
        chk("R1 bus_wr_valid in reset", {31'b0, bus_wr_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rsp_valid after reset", {31'b0, rsp_valid}, 0);
        // R1: SC straight after reset fails
        drive(mk(1, 1, 0, 32'h100, 32'h1));
        @(negedge clk);
        drive('0);
        chk("R1 SC after reset data", rsp_data, 0);
        chk("R1 SC after reset no write", {31'b0, bus_wr_valid}, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check_vec(VECS[i]);
        end
        drive('0);

        // R1: reset mid-run clears a live reservation
        drive(mk(1, 0, 0, 32'hA00, 0));
        @(negedge clk);
        drive('0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 rsp_valid during reset", {31'b0, rsp_valid}, 0);
        rst_n = 1'b1;
        drive(mk(1, 1, 0, 32'hA00, 32'h3));
        @(negedge clk);
        drive('0);
        chk("R1 SC after mid reset fails", rsp_data, 0);
        chk("R1 SC after mid reset no write", {31'b0, bus_wr_valid}, 0);

        // R13: two threads interleaved, long gap, both succeed
        drive(mk(1, 0, 1, 32'hB00, 0));
        @(negedge clk);
        drive(mk(1, 0, 2, 32'hC00, 0));
        @(negedge clk);
        drive('0);
        repeat (20) @(negedge clk);
        drive(mk(1, 1, 2, 32'hC00, 32'h77));
        @(negedge clk);
        chk("R13 t2 SC ok", rsp_data, 1);
        chk("R13 t2 bus write", {31'b0, bus_wr_valid}, 1);
        drive(mk(1, 1, 1, 32'hB00, 32'h66));
        @(negedge clk);
        drive('0);
        chk("R13 t1 SC ok", rsp_data, 1);
        chk("R13 t1 bus addr", bus_wr_addr, 32'hB00);
        @(negedge clk);
        chk("R3 write drops after one cycle", {31'b0, bus_wr_valid}, 0);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule